// File: doc/BRIEF.md
# Raster Pixel Window Weighting Stage

This block sits in front of a row transform in an image registration path. It accepts unsigned 8-bit pixels of a frame in raster order over a valid/ready handshake. Each pixel is recentred to a signed value by removing half of the pixel range. The signed value is then scaled by a separable two-dimensional Hamming weight. That weight is the product of a coefficient chosen by the pixel's row and a coefficient chosen by its column.

The block tracks the pixel's position itself. A start-of-frame marker on a pixel places that pixel at row 0, column 0. An end-of-line marker sends the next pixel to column 0 of the following row. Both coefficient tables are built at elaboration from the window formula. The result leaves as a signed fixed-point sample with eight fraction bits, qualified by a valid flag. A downstream ready input can hold the result back, and this stalls the whole pipeline.

Top module: `pixel_window`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sampleValid` is 0 and `pixReady` is 1.
- R2: An input byte p is recentred to the signed value p − 128, so 0 maps to −128, 128 maps to 0 and 255 maps to +127.
- R3: For a table of length N, coefficient n is round(256·(0.54 − 0.46·cos(2πn/(N−1)))), limited to at most 255. It is an unsigned value with eight fraction bits. The row table uses N = ROWS and the column table uses N = COLS.
- R4: The 2D weight is (rowCoef·colCoef + 128) >> 8, which again has eight fraction bits.
- R5: `sampleData` is the 16-bit two's-complement value (p − 128)·weight. That is S7.8: bit 15 is the sign and bits 7..0 are the fraction.
- R6: A pixel accepted with `pixSof` = 1 is placed at row 0, column 0, whatever the counters held before.
- R7: After a pixel accepted with `pixEol` = 1, the next pixel goes to column 0 of the next row.
- R8: Without an end-of-line marker, the column after COLS−1 is column 0 and the row does not change. The row after ROWS−1 is row 0.
- R9: With `sampleReady` held at 1, a pixel accepted at a clock edge shows up with `sampleValid` = 1 three cycles after the cycle in which it was offered.
- R10: While `sampleValid` = 1 and `sampleReady` = 0, `pixReady` is 0, and `sampleData` and `sampleValid` hold their values into the next cycle. Every accepted pixel leaves exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | Input pixel offered |
| pixReady | output | 1 | Pixel taken at this edge when pixValid is also 1 |
| pixData | input | 8 | Unsigned pixel byte |
| pixSof | input | 1 | Pixel is the first of a frame |
| pixEol | input | 1 | Pixel is the last of its line |
| sampleValid | output | 1 | sampleData holds a result |
| sampleReady | input | 1 | Downstream accepts the result |
| sampleData | output | 16 | Windowed sample, signed S7.8 |

## Verification
Two things often fall in the same cycle: a result held back by a low `sampleReady`, and a new pixel offered at the input. The bench provokes this by driving `sampleReady` from a pseudo-random pattern while the source keeps offering pixels with only a few gaps. It checks that `pixReady` drops, that the held sample stays the same, and that the ordered list of expected values drains with nothing left over and nothing extra. Marker corners are also exercised: a start-of-frame in the middle of a line, short lines closed by end-of-line, and a column wrap with no marker. Every value is compared against the window formula, computed in the bench with the real cosine.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;

  // number of register stages between pixel acceptance and output
  localparam int STAGES = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadIn;   // a pixel is taken this cycle
    logic advance;  // all stages move forward
  } pipeStrobe_t;

  // cosine by series around pi; input range 0..2pi
  function automatic real cosSeries(input real x);
    real y;
    real term;
    real sum;
    y    = x - 3.14159265358979323846;
    term = 1.0;
    sum  = 1.0;
    for (int k = 1; k <= 24; k++) begin
      term = -term * y * y / $itor((2 * k - 1) * (2 * k));
      sum  = sum + term;
    end
    return -sum;
  endfunction

  // Hamming weight scaled to coefW fraction bits, saturated below 1.0
  function automatic int hammingCoef(input int idx, input int len, input int coefW);
    int   scale;
    int   r;
    real  v;
    scale = 1 << coefW;
    if (len < 2) return scale - 1;
    v = $itor(scale) * (0.54 - 0.46 *
        cosSeries(2.0 * 3.14159265358979323846 * $itor(idx) / $itor(len - 1)));
    r = $rtoi(v + 0.5);
    if (r > scale - 1) r = scale - 1;
    if (r < 0) r = 0;
    return r;
  endfunction

endpackage

// File: rtl/pixwin_coef_rom.sv
module pixwin_coef_rom
  import pixwin_pkg::*;
#(
  parameter int LEN    = 256,
  parameter int COEF_W = 8,
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [COEF_W-1:0] coef
);

  logic [COEF_W-1:0] coefTab [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_entry
    assign coefTab[i] = COEF_W'(hammingCoef(i, LEN, COEF_W));
  end

  assign coef = coefTab[idx];

endmodule

// File: rtl/pixwin_ctrl.sv
module pixwin_ctrl
  import pixwin_pkg::*;
#(
  parameter int COLS = 256,
  parameter int ROWS = 256,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  input  logic             pixSof,
  input  logic             pixEol,
  input  logic             sampleReady,
  output logic             pixReady,
  output logic             sampleValid,
  output pipeStrobe_t      strobe,
  output logic [COL_W-1:0] colIdx,
  output logic [ROW_W-1:0] rowIdx
);

  logic [STAGES-1:0] stageVld;
  logic [COL_W-1:0]  colCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic              advance;
  logic              accept;

  // one stall for the whole pipe: move only when the output slot frees
  assign advance     = !stageVld[STAGES-1] || sampleReady;
  assign accept      = pixValid && advance;
  assign pixReady    = advance;
  assign sampleValid = stageVld[STAGES-1];

  assign strobe.loadIn  = accept;
  assign strobe.advance = advance;

  // position of the pixel now on the input
  assign colIdx = pixSof ? '0 : colCnt;
  assign rowIdx = pixSof ? '0 : rowCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageVld <= '0;
    end else if (advance) begin
      stageVld <= {stageVld[STAGES-2:0], accept};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (accept) begin
      if (pixEol) begin
        colCnt <= '0;
        rowCnt <= (rowIdx == ROW_W'(ROWS - 1)) ? '0 : rowIdx + 1'b1;
      end else begin
        colCnt <= (colIdx == COL_W'(COLS - 1)) ? '0 : colIdx + 1'b1;
        rowCnt <= rowIdx;
      end
    end
  end

endmodule

// File: rtl/pixwin_datapath.sv
module pixwin_datapath
  import pixwin_pkg::*;
#(
  parameter int COLS   = 256,
  parameter int ROWS   = 256,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int OUT_W = PIX_W + COEF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  pipeStrobe_t      strobe,
  input  logic [PIX_W-1:0] pixData,
  input  logic [COL_W-1:0] colIdx,
  input  logic [ROW_W-1:0] rowIdx,
  output logic [OUT_W-1:0] sampleData
);

  localparam int PROD_W = 2 * COEF_W;

  logic [COEF_W-1:0] rowCoef;
  logic [COEF_W-1:0] colCoef;

  pixwin_coef_rom #(.LEN(ROWS), .COEF_W(COEF_W)) u_rowRom (
    .idx (rowIdx),
    .coef(rowCoef)
  );

  pixwin_coef_rom #(.LEN(COLS), .COEF_W(COEF_W)) u_colRom (
    .idx (colIdx),
    .coef(colCoef)
  );

  // stage 1: recentred pixel and both coefficients
  logic signed [PIX_W-1:0] s1Pix;
  logic [COEF_W-1:0]       s1RowC;
  logic [COEF_W-1:0]       s1ColC;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Pix  <= '0;
      s1RowC <= '0;
      s1ColC <= '0;
    end else if (strobe.loadIn) begin
      s1Pix  <= {~pixData[PIX_W-1], pixData[PIX_W-2:0]};
      s1RowC <= rowCoef;
      s1ColC <= colCoef;
    end
  end

  // stage 2: 2D weight rounded back to COEF_W fraction bits
  logic [PROD_W-1:0]       wProd;
  logic [PROD_W-1:0]       wRound;
  logic signed [PIX_W-1:0] s2Pix;
  logic [COEF_W-1:0]       s2Weight;

  assign wProd  = s1RowC * s1ColC;
  assign wRound = wProd + PROD_W'(1 << (COEF_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      s2Pix    <= '0;
      s2Weight <= '0;
    end else if (strobe.advance) begin
      s2Pix    <= s1Pix;
      s2Weight <= wRound[PROD_W-1:COEF_W];
    end
  end

  // stage 3: signed pixel times unsigned weight
  logic signed [PIX_W+COEF_W:0] fullProd;
  logic signed [COEF_W:0]       weightSigned;

  assign weightSigned = $signed({1'b0, s2Weight});
  assign fullProd     = s2Pix * weightSigned;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleData <= '0;
    end else if (strobe.advance) begin
      sampleData <= fullProd[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/pixel_window.sv
module pixel_window
  import pixwin_pkg::*;
#(
  parameter int COLS   = 256,
  parameter int ROWS   = 256,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  localparam int OUT_W = PIX_W + COEF_W,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic [PIX_W-1:0] pixData,
  input  logic             pixSof,
  input  logic             pixEol,
  output logic             sampleValid,
  input  logic             sampleReady,
  output logic [OUT_W-1:0] sampleData
);

  pipeStrobe_t      strobe;
  logic [COL_W-1:0] colIdx;
  logic [ROW_W-1:0] rowIdx;

  pixwin_ctrl #(.COLS(COLS), .ROWS(ROWS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pixValid   (pixValid),
    .pixSof     (pixSof),
    .pixEol     (pixEol),
    .sampleReady(sampleReady),
    .pixReady   (pixReady),
    .sampleValid(sampleValid),
    .strobe     (strobe),
    .colIdx     (colIdx),
    .rowIdx     (rowIdx)
  );

  pixwin_datapath #(
    .COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W), .COEF_W(COEF_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .pixData   (pixData),
    .colIdx    (colIdx),
    .rowIdx    (rowIdx),
    .sampleData(sampleData)
  );

endmodule

// File: rtl/pixel_window_checker.sv
module pixel_window_checker #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  localparam int OUT_W = PIX_W + COEF_W
) (
  input logic             clk,
  input logic             rst,
  input logic             pixValid,
  input logic             pixReady,
  input logic             sampleValid,
  input logic             sampleReady,
  input logic [OUT_W-1:0] sampleData
);

  localparam int LIM_LO = -(1 << (PIX_W - 1)) * ((1 << COEF_W) - 1);
  localparam int LIM_HI = ((1 << (PIX_W - 1)) - 1) * ((1 << COEF_W) - 1);

  // R1: nothing valid and input open right after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!sampleValid && pixReady));

  // R10: a held result keeps its value
  assert_hold_sample_R10: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !sampleReady) |=> (sampleValid && $stable(sampleData)));

  // R10: no pixel taken while the output is blocked
  assert_block_input_R10: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !sampleReady) |-> !pixReady);

  // R5: results stay inside the S7.8 product range
  assert_sample_range_R5: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> ($signed(sampleData) >= LIM_LO && $signed(sampleData) <= LIM_HI));

endmodule

bind pixel_window pixel_window_checker #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .pixValid   (pixValid),
  .pixReady   (pixReady),
  .sampleValid(sampleValid),
  .sampleReady(sampleReady),
  .sampleData (sampleData)
);

// File: tb/pixel_window_bench.sv
module pixel_window_bench;

  localparam int CLK_PERIOD = 10;
  localparam int COLS = 8;
  localparam int ROWS = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        pixValid = 0;
  logic        pixReady;
  logic [7:0]  pixData = 0;
  logic        pixSof = 0;
  logic        pixEol = 0;
  logic        sampleValid;
  logic        sampleReady = 1;
  logic [15:0] sampleData;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  int rowCoef[ROWS];
  int colCoef[COLS];
  int mCol = 0;
  int mRow = 0;
  bit readyMode = 0;
  bit monOn = 0;
  bit prevStall = 0;
  logic [15:0] prevData = 0;
  logic [7:0] lfsr = 8'h5A;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pixel_window #(.COLS(COLS), .ROWS(ROWS)) u_pixel_window (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixReady(pixReady),
    .pixData(pixData), .pixSof(pixSof), .pixEol(pixEol),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .sampleData(sampleData)
  );

  function automatic int benchCoef(input int n, input int len);
    real v;
    int  r;
    v = 256.0 * (0.54 - 0.46 * $cos(2.0 * 3.14159265358979323846 * n / (len - 1)));
    r = $rtoi(v + 0.5);
    if (r > 255) r = 255;
    return r;
  endfunction

  // R2 R3 R4 R5 model of one accepted pixel, R6 R7 R8 position tracking
  task automatic modelAccept(input int p, input bit s, input bit e);
    int c;
    int r;
    int w;
    c = s ? 0 : mCol;
    r = s ? 0 : mRow;
    w = (rowCoef[r] * colCoef[c] + 128) >> 8;
    expQ.push_back((p - 128) * w);
    if (e) begin
      mCol = 0;
      mRow = (r == ROWS - 1) ? 0 : r + 1;
    end else begin
      mCol = (c == COLS - 1) ? 0 : c + 1;
      mRow = r;
    end
  endtask

  // called just after a rising edge; returns just after the accepting edge
  task automatic sendPix(input int p, input bit s, input bit e);
    bit done;
    done = 0;
    pixValid = 1; pixData = p[7:0]; pixSof = s; pixEol = e;
    while (!done) begin
      @(negedge clk);
      done = pixReady;
      @(posedge clk); #1;
    end
    modelAccept(p, s, e);
    pixValid = 0; pixSof = 0; pixEol = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // ready pattern driven just after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sampleReady = readyMode ? (lfsr[1:0] != 2'b00) : 1'b1;
    end
  end

  // output monitor, mid-cycle
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (prevStall) begin
        checks++;
        if (!(sampleValid && sampleData == prevData)) begin
          errors++;
          $display("FAIL R10 held sample changed: valid=%0b data=%0d expected data=%0d",
                   sampleValid, $signed(sampleData), $signed(prevData));
        end
      end
      if (sampleValid && !sampleReady) begin
        checks++;
        if (pixReady) begin
          errors++;
          $display("FAIL R10 pixReady=%0b while blocked, expected 0", pixReady);
        end
      end
      prevStall = sampleValid && !sampleReady;
      prevData  = sampleData;
      if (sampleValid && sampleReady) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R10 extra sample %0d, expected none", $signed(sampleData));
        end else begin
          int exp;
          exp = expQ.pop_front();
          if ($signed(sampleData) != exp) begin
            errors++;
            $display("FAIL R2 R3 R4 R5 sample actual=%0d expected=%0d",
                     $signed(sampleData), exp);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ROWS; i++) rowCoef[i] = benchCoef(i, ROWS);
    for (int i = 0; i < COLS; i++) colCoef[i] = benchCoef(i, COLS);

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sampleValid !== 1'b0 || pixReady !== 1'b1) begin
      errors++;
      $display("FAIL R1 valid=%0b ready=%0b expected valid=0 ready=1", sampleValid, pixReady);
    end
    @(posedge clk); #1;
    rst = 0;
    monOn = 1;
    idle(2);

    // R9 latency with open output
    sendPix(200, 1, 0);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (sampleValid !== 1'b0) begin
      errors++;
      $display("FAIL R9 early valid=%0b expected 0", sampleValid);
    end
    @(negedge clk);
    checks++;
    if (sampleValid !== 1'b1) begin
      errors++;
      $display("FAIL R9 valid=%0b at third cycle expected 1", sampleValid);
    end
    @(posedge clk); #1;
    idle(3);

    // R2 R3 R4 R5 R8 all pixel values over every position, with backpressure (R10)
    readyMode = 1;
    for (int k = 0; k < 256; k++) begin
      int pos;
      pos = k % (COLS * ROWS);
      sendPix((k * 67) & 255, pos == 0, (pos % COLS) == COLS - 1);
      if (k % 5 == 0) idle(1);
    end

    // R7 short lines closed by end-of-line, row wraps past ROWS-1 (R8)
    sendPix(10, 1, 0);
    for (int r = 0; r < 6; r++) begin
      sendPix(255, 0, 0);
      sendPix(0, 0, 1);
      sendPix(99, 0, 0);
    end

    // R8 column wrap with no marker keeps the row
    sendPix(255, 1, 0);
    for (int k = 0; k < 20; k++) sendPix(k * 13, 0, 0);

    // R6 start-of-frame in the middle of a line
    sendPix(0, 0, 0);
    sendPix(255, 1, 0);
    sendPix(1, 0, 0);

    // drain, R10 every accepted pixel left exactly once
    readyMode = 0;
    idle(20);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R10 pending=%0d expected 0", expQ.size());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule